// File: doc/BRIEF.md
# Pointer Address Generator

This block computes the byte address of a load or store that goes through a base pointer register, together with the pointer value that goes back to that register. Each request supplies a 32-bit base pointer, a 15-bit unsigned displacement, a 3-bit addressing mode, a flag that says whether the displacement counts bytes or elements, a 2-bit access size and a flag that permits unaligned word and double-word accesses.

An element displacement is turned into bytes by shifting it left by the size code. The mode selects three things: whether the offset is added or subtracted, whether the access uses the old pointer or the moved pointer, and whether the moved pointer is written back. An access that lands off its natural boundary, where that is not permitted, raises a flag. Its address is also rounded down to the boundary.

All results are registered, so they appear one clock after the request. The register file, the memory and the byte-lane alignment logic are outside this block.

Top module: `agu_top`

## Requirements
- R1: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While rst_ni is low, every output is zero, and asserting rst_ni clears the outputs without waiting for a clock edge.
- R2: When disp_bytes_i is 0, the byte offset equals disp_i shifted left by size_i. The size codes are 00 byte, 01 halfword, 10 word and 11 double word, that is 1, 2, 4 and 8 bytes.
- R3: When disp_bytes_i is 1, the byte offset equals disp_i zero-extended, with no scaling.
- R4: Mode 000 (offset add) gives addr_o = base + offset, and mode 001 (offset subtract) gives addr_o = base - offset. In both modes ptr_o = base and wb_en_o = 0.
- R5: Mode 010 (pre-increment) and mode 011 (pre-decrement) move the pointer by +offset or -offset. The moved value appears on both addr_o and ptr_o, and wb_en_o = 1.
- R6: Mode 100 (post-increment) and mode 101 (post-decrement) give addr_o = base. ptr_o carries base + offset or base - offset, and wb_en_o = 1.
- R7: All address and pointer arithmetic wraps modulo 2^32.
- R8: When the address is not a multiple of the access size and the access is not permitted to be unaligned, misalign_o is 1 and the log2(size) low bits of addr_o are forced to zero. ptr_o is never rounded. Byte accesses are never misaligned.
- R9: When unaligned_ok_i is 1, word and double-word accesses at any byte address give misalign_o = 0 and an unmodified addr_o. Halfword accesses are still checked as in R8.
- R10: When req_i is 0, wb_en_o and misalign_o are 0.
- R11: The reserved mode codes 110 and 111 behave exactly like mode 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | A memory access is present this cycle |
| base_i | input | 32 | Base pointer value |
| disp_i | input | 15 | Unsigned displacement |
| mode_i | input | 3 | Addressing mode |
| disp_bytes_i | input | 1 | 1: displacement in bytes, 0: in elements |
| size_i | input | 2 | Access size code |
| unaligned_ok_i | input | 1 | Permit unaligned word and double-word accesses |
| addr_o | output | 32 | Effective byte address |
| ptr_o | output | 32 | Pointer write-back value |
| wb_en_o | output | 1 | Pointer write-back enable |
| misalign_o | output | 1 | Misaligned access detected |

## Verification
The address function is tried with all six modes, plus the two reserved codes, at both displacement kinds and all four sizes. The vectors are chosen so that each one separates two things that could be confused:
- Adding from subtracting.
- Old pointer from moved pointer.
- Scaled offset from unscaled offset.
- Write-back from no write-back.

Wrap-around vectors cross zero in both directions, and the largest displacement at double-word size exercises the full width of the shifted offset. Alignment vectors place the same odd address under each size, with the permit flag both set and clear, so that rounding of the address, the flag itself and the untouched pointer can each be observed on their own.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AGU_OFF_ADD  = 3'b000,
    AGU_OFF_SUB  = 3'b001,
    AGU_PRE_INC  = 3'b010,
    AGU_PRE_DEC  = 3'b011,
    AGU_POST_INC = 3'b100,
    AGU_POST_DEC = 3'b101,
    AGU_RSV_6    = 3'b110,
    AGU_RSV_7    = 3'b111
  } agu_mode_e;

  typedef enum logic [1:0] {
    AGU_SZ_BYTE = 2'b00,
    AGU_SZ_HALF = 2'b01,
    AGU_SZ_WORD = 2'b10,
    AGU_SZ_DBL  = 2'b11
  } agu_size_e;

endpackage

// File: rtl/agu_disp_scale.sv
module agu_disp_scale #(
  parameter int DISP_W = 15,
  parameter int SIZE_W = 2,
  parameter int OFF_W  = DISP_W + (1 << SIZE_W) - 1
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic              disp_bytes_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [OFF_W-1:0]  off_o
);

  logic [OFF_W-1:0] disp_ext;

  assign disp_ext = {{(OFF_W-DISP_W){1'b0}}, disp_i};

  always_comb begin
    if (disp_bytes_i) off_o = disp_ext;
    else              off_o = disp_ext << size_i;
  end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 18
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        mode_i,
  output logic [ADDR_W-1:0] ea_raw_o,
  output logic [ADDR_W-1:0] ptr_nxt_o,
  output logic              wb_o
);

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] dif;
  agu_mode_e         mode;

  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off_i};
  assign sum     = base_i + off_ext;
  assign dif     = base_i - off_ext;
  assign mode    = agu_mode_e'(mode_i);

  always_comb begin
    ea_raw_o  = sum;
    ptr_nxt_o = base_i;
    wb_o      = 1'b0;
    unique case (mode)
      AGU_OFF_SUB:  ea_raw_o = dif;
      AGU_PRE_INC:  begin ea_raw_o = sum;    ptr_nxt_o = sum; wb_o = 1'b1; end
      AGU_PRE_DEC:  begin ea_raw_o = dif;    ptr_nxt_o = dif; wb_o = 1'b1; end
      AGU_POST_INC: begin ea_raw_o = base_i; ptr_nxt_o = sum; wb_o = 1'b1; end
      AGU_POST_DEC: begin ea_raw_o = base_i; ptr_nxt_o = dif; wb_o = 1'b1; end
      // offset add and reserved codes
      default:      ea_raw_o = sum;
    endcase
  end

endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 2,
  parameter int UNALN_MIN = 2, // smallest size code that may be unaligned
  localparam int LOW_W    = (1 << SIZE_W) - 1
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              unaligned_ok_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              mis_o
);

  logic [LOW_W-1:0] low_mask;
  logic             tolerate;
  logic             off_bound;

  // bit b must be zero when the access is wider than 2^b bytes
  for (genvar b = 0; b < LOW_W; b++) begin : g_mask
    assign low_mask[b] = (32'(size_i) > b);
  end

  assign tolerate  = unaligned_ok_i && (32'(size_i) >= UNALN_MIN);
  assign off_bound = |(ea_i[LOW_W-1:0] & low_mask);
  assign mis_o     = off_bound && !tolerate;

  always_comb begin
    ea_o = ea_i;
    if (mis_o) ea_o[LOW_W-1:0] = ea_i[LOW_W-1:0] & ~low_mask;
  end

endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int ADDR_W    = 32,
  parameter int DISP_W    = 15,
  parameter int SIZE_W    = 2,
  parameter int UNALN_MIN = 2,
  localparam int OFF_W    = DISP_W + (1 << SIZE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [2:0]        mode_i,
  input  logic              disp_bytes_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              unaligned_ok_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wb_en_o,
  output logic              misalign_o
);

  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] ea_raw;
  logic [ADDR_W-1:0] ea_fix;
  logic [ADDR_W-1:0] ptr_nxt;
  logic              wb;
  logic              mis;

  agu_disp_scale #(
    .DISP_W(DISP_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)
  ) u_scale (
    .disp_i(disp_i), .disp_bytes_i(disp_bytes_i), .size_i(size_i), .off_o(off)
  );

  agu_addr_calc #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W)
  ) u_calc (
    .base_i(base_i), .off_i(off), .mode_i(mode_i),
    .ea_raw_o(ea_raw), .ptr_nxt_o(ptr_nxt), .wb_o(wb)
  );

  agu_align_chk #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNALN_MIN(UNALN_MIN)
  ) u_align (
    .ea_i(ea_raw), .size_i(size_i), .unaligned_ok_i(unaligned_ok_i),
    .ea_o(ea_fix), .mis_o(mis)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      ptr_o      <= '0;
      wb_en_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      addr_o     <= ea_fix;
      ptr_o      <= ptr_nxt;
      wb_en_o    <= req_i && wb;
      misalign_o <= req_i && mis;
    end
  end

endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [2:0]        mode_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              wb_en_o,
  input logic              misalign_o
);

  logic primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  assert_no_wb_offset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(req_i) && ($past(mode_i) inside {3'b000, 3'b001})
    |-> !wb_en_o && (ptr_o == $past(base_i)));

  assert_reserved_no_wb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(req_i) && ($past(mode_i) inside {3'b110, 3'b111})
    |-> !wb_en_o && (ptr_o == $past(base_i)));

  assert_pre_same_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(req_i) && ($past(mode_i) inside {3'b010, 3'b011}) && !misalign_o
    |-> wb_en_o && (addr_o == ptr_o));

  assert_post_old_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(req_i) && ($past(mode_i) inside {3'b100, 3'b101}) && !misalign_o
    |-> wb_en_o && (addr_o == $past(base_i)));

  assert_mis_rounded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && misalign_o
    |-> ((addr_o[2:0] & 3'((32'd1 << $past(size_i)) - 1)) == 3'd0));

  assert_byte_never_mis_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(size_i) == 2'b00) |-> !misalign_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !$past(req_i) |-> !wb_en_o && !misalign_o);

endmodule

bind agu_top agu_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_agu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .base_i(base_i),
  .mode_i(mode_i), .size_i(size_i), .addr_o(addr_o), .ptr_o(ptr_o),
  .wb_en_o(wb_en_o), .misalign_o(misalign_o)
);

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;

  localparam int NV = 19;
  // {req, base, disp, mode, bytes, size, unaligned_ok, exp_addr, exp_ptr, exp_wb, exp_mis}
  localparam logic [120:0] VEC [NV] = '{
    {1'b1, 32'h0000_1000, 15'd3,      3'd0, 1'b0, 2'd2, 1'b0, 32'h0000_100C, 32'h0000_1000, 1'b0, 1'b0}, // R2 R4
    {1'b1, 32'h0000_1000, 15'd3,      3'd1, 1'b0, 2'd1, 1'b0, 32'h0000_0FFA, 32'h0000_1000, 1'b0, 1'b0}, // R2 R4
    {1'b1, 32'h0000_2000, 15'd5,      3'd2, 1'b1, 2'd0, 1'b0, 32'h0000_2005, 32'h0000_2005, 1'b1, 1'b0}, // R3 R5
    {1'b1, 32'h0000_2000, 15'd2,      3'd3, 1'b0, 2'd3, 1'b0, 32'h0000_1FF0, 32'h0000_1FF0, 1'b1, 1'b0}, // R2 R5
    {1'b1, 32'h0000_3000, 15'd4,      3'd4, 1'b0, 2'd2, 1'b0, 32'h0000_3000, 32'h0000_3010, 1'b1, 1'b0}, // R6
    {1'b1, 32'h0000_3000, 15'd1,      3'd5, 1'b0, 2'd1, 1'b0, 32'h0000_3000, 32'h0000_2FFE, 1'b1, 1'b0}, // R6
    {1'b1, 32'hFFFF_FFFC, 15'd2,      3'd2, 1'b0, 2'd2, 1'b0, 32'h0000_0004, 32'h0000_0004, 1'b1, 1'b0}, // R7
    {1'b1, 32'h0000_0004, 15'd3,      3'd5, 1'b0, 2'd3, 1'b0, 32'h0000_0000, 32'hFFFF_FFEC, 1'b1, 1'b1}, // R7 R8
    {1'b1, 32'h0000_1000, 15'd6,      3'd0, 1'b1, 2'd2, 1'b0, 32'h0000_1004, 32'h0000_1000, 1'b0, 1'b1}, // R3 R8
    {1'b1, 32'h0000_1000, 15'd6,      3'd0, 1'b1, 2'd2, 1'b1, 32'h0000_1006, 32'h0000_1000, 1'b0, 1'b0}, // R9
    {1'b1, 32'h0000_1001, 15'd0,      3'd0, 1'b0, 2'd1, 1'b1, 32'h0000_1000, 32'h0000_1001, 1'b0, 1'b1}, // R9 half
    {1'b1, 32'h0000_1003, 15'd1,      3'd4, 1'b1, 2'd3, 1'b1, 32'h0000_1003, 32'h0000_1004, 1'b1, 1'b0}, // R9 dbl
    {1'b1, 32'h0000_0000, 15'h7FFF,   3'd2, 1'b0, 2'd3, 1'b0, 32'h0003_FFF8, 32'h0003_FFF8, 1'b1, 1'b0}, // R2 max
    {1'b1, 32'h0000_0500, 15'd1,      3'd6, 1'b0, 2'd2, 1'b0, 32'h0000_0504, 32'h0000_0500, 1'b0, 1'b0}, // R11
    {1'b1, 32'h0000_0500, 15'd1,      3'd7, 1'b0, 2'd2, 1'b0, 32'h0000_0504, 32'h0000_0500, 1'b0, 1'b0}, // R11
    {1'b0, 32'h0000_3000, 15'd4,      3'd4, 1'b0, 2'd2, 1'b0, 32'h0000_3000, 32'h0000_3010, 1'b0, 1'b0}, // R10
    {1'b0, 32'h0000_1006, 15'd0,      3'd0, 1'b0, 2'd2, 1'b0, 32'h0000_1004, 32'h0000_1006, 1'b0, 1'b0}, // R10
    {1'b1, 32'h0000_0007, 15'd0,      3'd0, 1'b1, 2'd0, 1'b0, 32'h0000_0007, 32'h0000_0007, 1'b0, 1'b0}, // R8 byte
    {1'b1, 32'h0000_2001, 15'd1,      3'd2, 1'b0, 2'd1, 1'b0, 32'h0000_2002, 32'h0000_2003, 1'b1, 1'b1}  // R5 R8
  };
  localparam int TAG [NV] = '{4, 4, 5, 5, 6, 6, 7, 8, 8, 9, 9, 9, 2, 11, 11, 10, 10, 8, 8};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [14:0] disp_i = '0;
  logic [2:0]  mode_i = '0;
  logic        disp_bytes_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic        unaligned_ok_i = 1'b0;
  logic [31:0] addr_o, ptr_o;
  logic        wb_en_o, misalign_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  agu_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .base_i(base_i),
    .disp_i(disp_i), .mode_i(mode_i), .disp_bytes_i(disp_bytes_i),
    .size_i(size_i), .unaligned_ok_i(unaligned_ok_i),
    .addr_o(addr_o), .ptr_o(ptr_o), .wb_en_o(wb_en_o), .misalign_o(misalign_o)
  );

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [120:0] v);
    {req_i, base_i, disp_i, mode_i, disp_bytes_i, size_i, unaligned_ok_i} = v[120:66];
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs held at zero in reset despite active inputs
    drive(VEC[2]);
    repeat (3) @(posedge clk_i);
    #1;
    chk(1, "reset addr", addr_o, 32'h0);
    chk(1, "reset ptr", ptr_o, 32'h0);
    chk(1, "reset wb", {31'b0, wb_en_o}, 32'h0);
    chk(1, "reset mis", {31'b0, misalign_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i]);
      @(posedge clk_i);
      #1;
      chk(TAG[i], $sformatf("vec%0d addr", i), addr_o, VEC[i][65:34]);
      chk(TAG[i], $sformatf("vec%0d ptr", i), ptr_o, VEC[i][33:2]);
      chk(TAG[i], $sformatf("vec%0d wb", i), {31'b0, wb_en_o}, {31'b0, VEC[i][1]});
      chk(TAG[i], $sformatf("vec%0d mis", i), {31'b0, misalign_o}, {31'b0, VEC[i][0]});
    end

    // R1: one-cycle latency, output holds until the next edge
    @(negedge clk_i);
    req_i = 1'b1; base_i = 32'h0000_9000; disp_i = '0; mode_i = 3'd0;
    disp_bytes_i = 1'b1; size_i = 2'd0; unaligned_ok_i = 1'b0;
    #1;
    chk(1, "latency hold", addr_o, 32'h0000_2002);
    @(posedge clk_i);
    #1;
    chk(1, "latency update", addr_o, 32'h0000_9000);

    // R1: asynchronous clear away from a clock edge
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk(1, "async clear addr", addr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 vs R2: same displacement, byte kind at word size stays unscaled
    @(negedge clk_i);
    req_i = 1'b1; base_i = 32'h0000_4000; disp_i = 15'd8; mode_i = 3'd4;
    disp_bytes_i = 1'b1; size_i = 2'd2; unaligned_ok_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk(3, "byte disp ptr", ptr_o, 32'h0000_4008);
    @(negedge clk_i);
    disp_bytes_i = 1'b0;
    @(posedge clk_i);
    #1;
    chk(2, "elem disp ptr", ptr_o, 32'h0000_4020);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule